// File: doc/BRIEF.md
# Receive Bit-Oriented Code Detector

This block sits behind the framer of a T1 receiver that runs extended-superframe framing. It watches the serial data-link bit stream, one bit per `dl_valid` strobe. In that stream it looks for 16-bit code words made of eight ones, a zero, a 6-bit message and a closing zero.

A message is accepted only after the same code word has repeated back to back a programmable number of times. This integration filter prevents line errors from producing false messages. Once a message has been accepted, the block latches it and raises a sticky detect flag. A separate disintegration filter raises a sticky clear flag when no valid code word has been seen for a programmable number of data-link bits.

Host software reads the two flags and clears each one with a one-cycle pulse. Each flag can drive a shared active-low interrupt line through its own enable. After the host clears the detect flag, the same code repeating again does not raise the flag a second time. The flag rises again only when a different code is accepted, or when the same code is accepted after a clear event.

Top module: `boc_rx_detect`

## Requirements
- R1: After reset, `msg` is 0, `det_flag` and `clr_flag` are 0 and `irq_n` is 1.
- R2: Bits are taken in arrival order. A code word is matched when the 16 most recent valid bits are, oldest first, eight ones, a zero, six message bits and a zero. The first-arriving message bit becomes `msg[5]`. With `integ_sel` = 0, one matched word qualifies its message.
- R3: `integ_sel` values 0, 1, 2 and 3 require 1, 3, 5 and 7 consecutive identical code words before qualification. Consecutive means each word ends exactly 16 valid bits after the previous one.
- R4: A matched word with a different message, or one that does not follow the previous word after exactly 16 bits, restarts the count at one. `msg` changes only at a qualification and then takes the qualified message.
- R5: At a qualification, `det_flag` is set if the message differs from the stored one, or if a clear event has occurred since the last qualification; otherwise it is left unchanged. A `det_clr` pulse clears `det_flag` unless it is set in the same cycle.
- R6: While a message is qualified, `disint_sel` values 0, 1, 2 and 3 set `clr_flag` on the 16th, 32nd, 64th or 128th consecutive valid bit that completes no code word. This is a clear event and happens once per qualification. A `clr_clr` pulse clears `clr_flag` unless it is set in the same cycle.
- R7: While `esf_mode` is 0, data-link bits are ignored. Partial words and integration progress are discarded. `msg`, `det_flag` and `clr_flag` do not change, except that a host clear pulse still clears its own flag.
- R8: `irq_n` is 0 exactly when (`det_flag` and `det_irq_en`) or (`clr_flag` and `clr_irq_en`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dl_bit | input | 1 | Data-link bit |
| dl_valid | input | 1 | Strobe marking `dl_bit` as a new data-link bit |
| esf_mode | input | 1 | 1 when the receiver runs extended-superframe framing |
| integ_sel | input | 2 | Integration filter select (1/3/5/7 words) |
| disint_sel | input | 2 | Disintegration select (16/32/64/128 bits) |
| det_clr | input | 1 | Write-one-to-clear pulse for `det_flag` |
| clr_clr | input | 1 | Write-one-to-clear pulse for `clr_flag` |
| det_irq_en | input | 1 | Interrupt enable for `det_flag` |
| clr_irq_en | input | 1 | Interrupt enable for `clr_flag` |
| msg | output | 6 | Last qualified message |
| det_flag | output | 1 | Sticky detect status |
| clr_flag | output | 1 | Sticky clear status |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions check the following on every cycle:
- the message stays frozen while the receiver is out of extended-superframe mode;
- a change of message is always accompanied by a raised detect flag;
- a detect flag rises only after an accepted data-link bit;
- host clear pulses take effect;
- the interrupt line agrees with the enabled flags.

Several properties need whole bit sequences and can be shown only by the bench's scenarios. These are the exact word count each filter select demands, the restart on a different code or a broken spacing, and the suppression of a repeated detect until an absence has been declared. The same holds for the exact bit on which each disintegration length fires.

// File: rtl/boc_pkg.sv
`timescale 1ns/1ps
package boc_pkg;
  localparam int MSG_W  = 6;
  localparam int HDR_W  = 8;
  localparam int WORD_W = HDR_W + MSG_W + 2;
  typedef logic [MSG_W-1:0] boc_msg_t;
endpackage

// File: rtl/boc_word_shifter.sv
`timescale 1ns/1ps
module boc_word_shifter
  import boc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     step,
  input  logic     idle,
  input  logic     bit_in,
  output logic     match,
  output boc_msg_t msg_in
);
  // holds the WORD_W-1 previous bits; the incoming bit completes the window
  logic [WORD_W-2:0] hist_q, hist_d;
  logic [WORD_W-1:0] win;

  assign win    = {hist_q, bit_in};
  assign match  = (win[WORD_W-1 -: HDR_W] == {HDR_W{1'b1}}) && !win[MSG_W+1] && !win[0];
  assign msg_in = win[MSG_W:1];

  always_comb begin
    hist_d = hist_q;
    if (idle)      hist_d = '0;
    else if (step) hist_d = win[WORD_W-2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end
endmodule

// File: rtl/boc_absence_timer.sv
`timescale 1ns/1ps
module boc_absence_timer
  import boc_pkg::*;
#(
  parameter int GAP_W       = 8,
  parameter int DISINT_BASE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       idle,
  input  logic       match,
  input  logic [1:0] sel,
  output logic       seq_ok,
  output logic       absent_evt
);
  localparam logic [GAP_W-1:0] GAP_SAT  = {GAP_W{1'b1}};
  localparam logic [GAP_W-1:0] GAP_SEQ  = GAP_W'(WORD_W - 1);
  localparam logic [GAP_W-1:0] GAP_BASE = GAP_W'(DISINT_BASE);

  logic [GAP_W-1:0] gap_q, gap_d, gap_inc, limit;

  assign limit      = GAP_BASE << sel;
  assign gap_inc    = (gap_q == GAP_SAT) ? gap_q : gap_q + GAP_W'(1);
  // previous code word ended exactly one word length before this bit
  assign seq_ok     = (gap_q == GAP_SEQ);
  assign absent_evt = step && !match && (gap_inc == limit);

  always_comb begin
    gap_d = gap_q;
    if (idle)      gap_d = '0;
    else if (step) gap_d = match ? '0 : gap_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap_q <= '0;
    else        gap_q <= gap_d;
  end
endmodule

// File: rtl/boc_integrator.sv
`timescale 1ns/1ps
module boc_integrator
  import boc_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       idle,
  input  logic       match,
  input  boc_msg_t   msg_in,
  input  logic       seq_ok,
  input  logic [1:0] sel,
  output logic       qual_evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_new, target;
  boc_msg_t         cand_q, cand_d;
  logic             cont;

  assign target   = CNT_W'({sel, 1'b1});
  assign cont     = seq_ok && (cnt_q != '0) && (msg_in == cand_q);
  assign cnt_new  = !cont ? CNT_W'(1) : ((cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_W'(1));
  assign qual_evt = step && match && (cnt_new == target) && (!cont || (cnt_q != target));

  always_comb begin
    cnt_d  = cnt_q;
    cand_d = cand_q;
    if (idle) begin
      cnt_d  = '0;
      cand_d = '0;
    end else if (step && match) begin
      cnt_d  = cnt_new;
      cand_d = msg_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cand_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      cand_q <= cand_d;
    end
  end
endmodule

// File: rtl/boc_status.sv
`timescale 1ns/1ps
module boc_status
  import boc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     qual_evt,
  input  boc_msg_t qual_msg,
  input  logic     absent_evt,
  input  logic     det_clr,
  input  logic     clr_clr,
  input  logic     det_irq_en,
  input  logic     clr_irq_en,
  output boc_msg_t msg,
  output logic     det_flag,
  output logic     clr_flag,
  output logic     irq_n
);
  boc_msg_t msg_q, msg_d;
  logic     act_q, act_d, det_q, det_d, clr_q, clr_d;
  logic     det_set, clr_set;

  assign det_set = qual_evt && ((qual_msg != msg_q) || !act_q);
  assign clr_set = absent_evt && act_q;

  always_comb begin
    msg_d = msg_q;
    act_d = act_q;
    if (qual_evt) begin
      msg_d = qual_msg;
      act_d = 1'b1;
    end else if (clr_set) begin
      act_d = 1'b0;
    end
    det_d = det_set | (det_q & ~det_clr);
    clr_d = clr_set | (clr_q & ~clr_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_q <= '0;
      act_q <= 1'b0;
      det_q <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      msg_q <= msg_d;
      act_q <= act_d;
      det_q <= det_d;
      clr_q <= clr_d;
    end
  end

  assign msg      = msg_q;
  assign det_flag = det_q;
  assign clr_flag = clr_q;
  assign irq_n    = ~((det_q & det_irq_en) | (clr_q & clr_irq_en));
endmodule

// File: rtl/boc_rx_detect.sv
`timescale 1ns/1ps
module boc_rx_detect
  import boc_pkg::*;
#(
  parameter int CNT_W       = 3,
  parameter int GAP_W       = 8,
  parameter int DISINT_BASE = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dl_bit,
  input  logic             dl_valid,
  input  logic             esf_mode,
  input  logic [1:0]       integ_sel,
  input  logic [1:0]       disint_sel,
  input  logic             det_clr,
  input  logic             clr_clr,
  input  logic             det_irq_en,
  input  logic             clr_irq_en,
  output logic [MSG_W-1:0] msg,
  output logic             det_flag,
  output logic             clr_flag,
  output logic             irq_n
);
  logic [1:0] rst_pipe;
  logic       core_rst_n;
  logic       step, idle, match, seq_ok, absent_evt, qual_evt;
  boc_msg_t   msg_in;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign core_rst_n = rst_pipe[1];

  assign idle = !esf_mode;
  assign step = dl_valid && esf_mode;

  boc_word_shifter u_shift (
    .clk(clk), .rst_n(core_rst_n), .step(step), .idle(idle),
    .bit_in(dl_bit), .match(match), .msg_in(msg_in)
  );

  boc_absence_timer #(.GAP_W(GAP_W), .DISINT_BASE(DISINT_BASE)) u_absent (
    .clk(clk), .rst_n(core_rst_n), .step(step), .idle(idle), .match(match),
    .sel(disint_sel), .seq_ok(seq_ok), .absent_evt(absent_evt)
  );

  boc_integrator #(.CNT_W(CNT_W)) u_integ (
    .clk(clk), .rst_n(core_rst_n), .step(step), .idle(idle), .match(match),
    .msg_in(msg_in), .seq_ok(seq_ok), .sel(integ_sel), .qual_evt(qual_evt)
  );

  boc_status u_stat (
    .clk(clk), .rst_n(core_rst_n), .qual_evt(qual_evt), .qual_msg(msg_in),
    .absent_evt(absent_evt), .det_clr(det_clr), .clr_clr(clr_clr),
    .det_irq_en(det_irq_en), .clr_irq_en(clr_irq_en),
    .msg(msg), .det_flag(det_flag), .clr_flag(clr_flag), .irq_n(irq_n)
  );
endmodule

// File: rtl/boc_rx_detect_chk.sv
`timescale 1ns/1ps
module boc_rx_detect_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dl_valid,
  input logic       esf_mode,
  input logic       det_clr,
  input logic       clr_clr,
  input logic       det_irq_en,
  input logic       clr_irq_en,
  input logic [5:0] msg,
  input logic       det_flag,
  input logic       clr_flag,
  input logic       irq_n
);
  // R7
  mode_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !esf_mode |=> ($stable(msg) && !$rose(det_flag) && !$rose(clr_flag)));

  // R4
  msg_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(msg) |-> det_flag);

  // R5
  det_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det_flag) |-> $past(dl_valid && esf_mode));

  // R5
  det_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (det_clr && !(dl_valid && esf_mode)) |=> !det_flag);

  // R6
  clr_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_clr && !(dl_valid && esf_mode)) |=> !clr_flag);

  // R8
  irq_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((det_flag && det_irq_en) || (clr_flag && clr_irq_en)) |-> !irq_n);

  // R8
  irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!det_flag && !clr_flag) |-> irq_n);
endmodule

bind boc_rx_detect boc_rx_detect_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dl_valid(dl_valid), .esf_mode(esf_mode),
  .det_clr(det_clr), .clr_clr(clr_clr), .det_irq_en(det_irq_en),
  .clr_irq_en(clr_irq_en), .msg(msg), .det_flag(det_flag),
  .clr_flag(clr_flag), .irq_n(irq_n)
);

// File: tb/boc_rx_detect_bench.sv
`timescale 1ns/1ps
module boc_rx_detect_bench;
  logic       clk, rst_n, dl_bit, dl_valid, esf_mode;
  logic [1:0] integ_sel, disint_sel;
  logic       det_clr, clr_clr, det_irq_en, clr_irq_en;
  logic [5:0] msg;
  logic       det_flag, clr_flag, irq_n;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference model state
  logic [15:0] m_sr;
  int          m_gap, m_cnt;
  logic [5:0]  m_cand, m_msg;
  bit          m_act, m_det, m_clr;

  boc_rx_detect u_boc_rx_detect (
    .clk(clk), .rst_n(rst_n), .dl_bit(dl_bit), .dl_valid(dl_valid),
    .esf_mode(esf_mode), .integ_sel(integ_sel), .disint_sel(disint_sel),
    .det_clr(det_clr), .clr_clr(clr_clr), .det_irq_en(det_irq_en),
    .clr_irq_en(clr_irq_en), .msg(msg), .det_flag(det_flag),
    .clr_flag(clr_flag), .irq_n(irq_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int filt_len(logic [1:0] s);
    return 2 * int'(s) + 1;
  endfunction

  function automatic int disint_len(logic [1:0] s);
    return 16 << s;
  endfunction

  function automatic bit exp_irq_n();
    return !((m_det && det_irq_en) || (m_clr && clr_irq_en));
  endfunction

  task automatic chk(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic model_step(bit v, bit b, bit dc, bit cc);
    bit sd = 0;
    bit sc = 0;
    logic [15:0] w;
    logic [5:0] mm;
    bit hit, cont;
    int nc;
    if (!esf_mode) begin
      m_sr = '0; m_cnt = 0; m_cand = '0; m_gap = 0;
    end else if (v) begin
      w = {m_sr[14:0], b};
      hit = (w[15:8] == 8'hFF) && !w[7] && !w[0];
      mm = w[6:1];
      if (hit) begin
        cont = (m_gap == 15) && (m_cnt != 0) && (mm == m_cand);
        nc = cont ? ((m_cnt == 7) ? 7 : m_cnt + 1) : 1;
        if (nc == filt_len(integ_sel) && (!cont || m_cnt != nc)) begin
          if (mm != m_msg || !m_act) sd = 1;
          m_msg = mm; m_act = 1;
        end
        m_cnt = nc; m_cand = mm; m_gap = 0;
      end else begin
        m_gap = (m_gap == 255) ? 255 : m_gap + 1;
        if (m_act && m_gap == disint_len(disint_sel)) begin
          sc = 1; m_act = 0;
        end
      end
      m_sr = w;
    end
    m_det = sd | (m_det & !dc);
    m_clr = sc | (m_clr & !cc);
  endtask

  task automatic cyc(bit v, bit b, bit dc, bit cc);
    @(negedge clk);
    dl_valid = v; dl_bit = b; det_clr = dc; clr_clr = cc;
    @(posedge clk);
    #1;
    model_step(v, b, dc, cc);
    chk("R4 model msg", int'(msg), int'(m_msg));
    chk("R5 model det_flag", int'(det_flag), int'(m_det));
    chk("R6 model clr_flag", int'(clr_flag), int'(m_clr));
    chk("R8 model irq_n", int'(irq_n), int'(exp_irq_n()));
  endtask

  task automatic send_word(logic [5:0] m);
    logic [15:0] w = {8'hFF, 1'b0, m, 1'b0};
    for (int i = 15; i >= 0; i--) cyc(1'b1, w[i], 1'b0, 1'b0);
  endtask

  task automatic send_bad_word(logic [5:0] m, int flip);
    logic [15:0] w = {8'hFF, 1'b0, m, 1'b0};
    w[flip] = ~w[flip];
    for (int i = 15; i >= 0; i--) cyc(1'b1, w[i], 1'b0, 1'b0);
  endtask

  task automatic send_zeros(int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic host_clear(bit dc, bit cc);
    cyc(1'b0, 1'b0, dc, cc);
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_b0c1));
    rst_n = 1'b0; dl_bit = 1'b0; dl_valid = 1'b0; esf_mode = 1'b1;
    integ_sel = 2'd0; disint_sel = 2'd3; det_clr = 1'b0; clr_clr = 1'b0;
    det_irq_en = 1'b1; clr_irq_en = 1'b1;
    m_sr = '0; m_gap = 0; m_cnt = 0; m_cand = '0; m_msg = '0;
    m_act = 0; m_det = 0; m_clr = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) cyc(1'b0, 1'b0, 1'b0, 1'b0);

    // R1 reset state
    chk("R1 msg", int'(msg), 0);
    chk("R1 det_flag", int'(det_flag), 0);
    chk("R1 clr_flag", int'(clr_flag), 0);
    chk("R1 irq_n", int'(irq_n), 1);

    // R2 single word qualifies with filter 0; first message bit lands in msg[5]
    send_word(6'h25);
    chk("R2 det after one word", int'(det_flag), 1);
    chk("R2 msg bit order", int'(msg), 'h25);

    // R3 five consecutive words with filter 2
    host_clear(1'b1, 1'b0);
    integ_sel = 2'd2;
    repeat (4) send_word(6'h2A);
    chk("R3 det held before 5th word", int'(det_flag), 0);
    chk("R4 msg held before qualification", int'(msg), 'h25);
    send_word(6'h2A);
    chk("R3 det on 5th word", int'(det_flag), 1);
    chk("R3 msg on 5th word", int'(msg), 'h2A);

    // R5 same code keeps det clear, even after a broken run
    host_clear(1'b1, 1'b0);
    chk("R5 det cleared by host", int'(det_flag), 0);
    repeat (3) send_word(6'h2A);
    send_zeros(8);
    repeat (5) send_word(6'h2A);
    chk("R5 same code no re-detect", int'(det_flag), 0);

    // R6 clear event on the 16th bit with no code
    disint_sel = 2'd0;
    send_zeros(15);
    chk("R6 clr not yet at bit 15", int'(clr_flag), 0);
    send_zeros(1);
    chk("R6 clr at bit 16", int'(clr_flag), 1);
    send_zeros(40);
    chk("R6 one clear per qualification", int'(clr_flag), 1);

    // R5 same code detected again after a clear event
    repeat (5) send_word(6'h2A);
    chk("R5 re-detect after clear", int'(det_flag), 1);

    // R8 interrupt gating
    det_irq_en = 1'b0;
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8 clr alone drives irq", int'(irq_n), 0);
    host_clear(1'b0, 1'b1);
    chk("R8 masked det gives no irq", int'(irq_n), 1);
    det_irq_en = 1'b1;
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8 enabled det drives irq", int'(irq_n), 0);
    host_clear(1'b1, 1'b0);
    chk("R8 irq released", int'(irq_n), 1);

    // R7 esf low ignores words
    integ_sel = 2'd0; disint_sel = 2'd3;
    esf_mode = 1'b0;
    repeat (3) send_word(6'h07);
    chk("R7 det ignored", int'(det_flag), 0);
    chk("R7 msg ignored", int'(msg), 'h2A);
    esf_mode = 1'b1;
    send_word(6'h07);
    chk("R7 det after esf returns", int'(det_flag), 1);
    chk("R7 msg after esf returns", int'(msg), 'h07);

    // R4 different code restarts integration
    host_clear(1'b1, 1'b0);
    integ_sel = 2'd1;
    repeat (2) send_word(6'h33);
    repeat (2) send_word(6'h0C);
    chk("R4 restart keeps det low", int'(det_flag), 0);
    chk("R4 msg unchanged before qual", int'(msg), 'h07);
    send_word(6'h0C);
    chk("R4 det on 3rd new word", int'(det_flag), 1);
    chk("R4 msg new code", int'(msg), 'h0C);

    // constrained random against the reference model
    for (int k = 0; k < 80; k++) begin
      int r = int'($urandom % 10);
      logic [5:0] pool [3] = '{6'h15, 6'h2A, 6'h3E};
      if ($urandom % 4 == 0) integ_sel = 2'($urandom % 4);
      if ($urandom % 4 == 0) disint_sel = 2'($urandom % 3);
      det_irq_en = 1'($urandom % 2);
      clr_irq_en = 1'($urandom % 2);
      if (r < 6)       send_word(pool[$urandom % 3]);
      else if (r == 6) send_bad_word(pool[$urandom % 3], int'($urandom % 16));
      else if (r == 7) send_zeros(1 + int'($urandom % 40));
      else if (r == 8) host_clear(1'($urandom % 2), 1'($urandom % 2));
      else begin
        esf_mode = 1'b0;
        send_zeros(3);
        esf_mode = 1'b1;
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule